// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves data between two 8-bit ports, A and B, and can store it on the way. Each transfer direction has its own bank of level-sensitive storage and its own three active-low controls: a path enable, a latch enable and an output enable. When both the path enable and the latch enable of a direction are low, data passes straight through. A rising edge on either of them freezes the last value seen. The output enable decides only whether the destination port is driven.

Each port is modelled as an input bus, an output bus and a drive-enable, so the block contains no tri-state nets. An input strobe per port says whether an external agent is actively driving that port. While nobody drives it, a keeper holds the port's last driven level, so storage never picks up an undefined value. A contention flag rises whenever both destination drivers are on together.

The design is synchronous to `clk_i`. Storage is written on each clock edge while a direction is open, and the data outputs show the open input combinationally. Reset is asynchronous and active low.

Top module: `latched_bus_xcvr`

## Requirements
- R1: While a direction's path enable and latch enable are both low (and reset is released), its data output equals its source port's effective input in the same cycle and follows it as it changes.
- R2: When the latch enable of an open direction goes high, the data output holds the value the source port had at the last clock edge while the direction was open.
- R3: When the path enable of an open direction goes high while the latch enable stays low, the data output holds the captured value in the same way as in R2.
- R4: While a direction is closed, changes on its source port have no effect on its data output.
- R5: A direction's drive-enable output is 1 only while its path enable and output enable are both low. In every other case it is 0.
- R6: With the output enable high, the direction still passes data through and captures it on its data output. A later low output enable then drives the value that was stored.
- R7: While reset is low, both drive-enables are 0, both data outputs are 0 and the contention flag is 0. Storage and keepers restart from 0 after reset is released.
- R8: While a port's drive strobe is 0, its effective input is the value the port had at the last clock edge at which it was driven. The value of the port's input bus is ignored.
- R9: The contention flag is 1 exactly when the A-side and B-side drive-enables are both 1.
- R10: The two directions are independent. Controls and data of one direction never change the data output of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_data_i | input | 8 | Value seen on port A |
| a_drive_i | input | 1 | 1 when an external agent drives port A |
| b_data_i | input | 8 | Value seen on port B |
| b_drive_i | input | 1 | 1 when an external agent drives port B |
| ab_en_ni | input | 1 | A-to-B path enable, active low |
| ab_le_ni | input | 1 | A-to-B latch enable, active low |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ba_en_ni | input | 1 | B-to-A path enable, active low |
| ba_le_ni | input | 1 | B-to-A latch enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| a_data_o | output | 8 | Value presented toward port A (B-to-A path) |
| a_oe_o | output | 1 | Drive-enable for port A |
| b_data_o | output | 8 | Value presented toward port B (A-to-B path) |
| b_oe_o | output | 1 | Drive-enable for port B |
| contention_o | output | 1 | Both ports are driven at once |

## Verification
The bench closes each direction in two ways: by raising the latch enable, and by raising the path enable with the latch enable still low. It changes the source data in the same half-cycle as the closing edge. A design that captured on the wrong edge, or that ignored the path enable as a capture source, would show the new data instead of the value from the previous edge. It also latches while the output enable is high and then turns the output on, which catches a design that ties storage to the output enable. Other tests release a port's drive strobe while the input bus carries junk, and toggle one direction while the other is holding, which exposes a missing keeper and any crosstalk between the two banks.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned NUM_DIR    = 2;

  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_bus_keeper.sv
module xcvr_bus_keeper #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic              drv_i,
  output logic [DATA_W-1:0] eff_o
);
  logic [DATA_W-1:0] held_q;

  assign eff_o = drv_i ? din_i : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= eff_o;
  end

  assert_keeper_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(drv_i)) |-> (held_q == $past(din_i)));

  assert_keeper_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !drv_i && !$past(drv_i)) |-> $stable(eff_o));
endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
  import xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dir_ctrl_t         ctrl_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              drv_o
);
  logic              open_w;
  logic [DATA_W-1:0] store_q;

  // open: level transparency; storage tracks input on every edge while open
  assign open_w = rst_ni && !ctrl_i.en_n && !ctrl_i.le_n;
  assign dout_o = open_w ? src_i : store_q;
  assign drv_o  = rst_ni && !ctrl_i.en_n && !ctrl_i.oe_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     store_q <= '0;
    else if (open_w) store_q <= src_i;
  end

  assert_capture_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(open_w) && !open_w) |-> (dout_o == $past(src_i)));

  assert_closed_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !open_w && !$past(open_w)) |-> $stable(dout_o));

  assert_drive_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.oe_n || ctrl_i.en_n) |-> !drv_o);

  assert_reset_quiet_R7: assert property (@(posedge clk_i)
    !rst_ni |-> (!drv_o && dout_o == '0));
endmodule

// File: rtl/xcvr_contention_mon.sv
module xcvr_contention_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_drv_i,
  input  logic b_drv_i,
  input  logic ab_oe_ni,
  input  logic ba_oe_ni,
  output logic clash_o
);
  assign clash_o = a_drv_i & b_drv_i;

  assert_clash_needs_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash_o |-> (!ab_oe_ni && !ba_oe_ni));

  assert_clash_reset_R7: assert property (@(posedge clk_i)
    !rst_ni |-> !clash_o);
endmodule

// File: rtl/latched_bus_xcvr.sv
module latched_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              a_drive_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic              b_drive_i,
  input  logic              ab_en_ni,
  input  logic              ab_le_ni,
  input  logic              ab_oe_ni,
  input  logic              ba_en_ni,
  input  logic              ba_le_ni,
  input  logic              ba_oe_ni,
  output logic [DATA_W-1:0] a_data_o,
  output logic              a_oe_o,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_oe_o,
  output logic              contention_o
);
  // index 0: port A / A-to-B path, index 1: port B / B-to-A path
  logic [DATA_W-1:0] port_din [NUM_DIR];
  logic              port_drv [NUM_DIR];
  logic [DATA_W-1:0] port_eff [NUM_DIR];
  dir_ctrl_t         dir_ctrl [NUM_DIR];
  logic [DATA_W-1:0] dir_dout [NUM_DIR];
  logic              dir_drv  [NUM_DIR];

  assign port_din[0] = a_data_i;
  assign port_din[1] = b_data_i;
  assign port_drv[0] = a_drive_i;
  assign port_drv[1] = b_drive_i;
  assign dir_ctrl[0] = '{en_n: ab_en_ni, le_n: ab_le_ni, oe_n: ab_oe_ni};
  assign dir_ctrl[1] = '{en_n: ba_en_ni, le_n: ba_le_ni, oe_n: ba_oe_ni};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_bus_keeper #(.DATA_W(DATA_W)) u_keep (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (port_din[d]),
      .drv_i  (port_drv[d]),
      .eff_o  (port_eff[d])
    );

    xcvr_dir_path #(.DATA_W(DATA_W)) u_path (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (dir_ctrl[d]),
      .src_i  (port_eff[d]),
      .dout_o (dir_dout[d]),
      .drv_o  (dir_drv[d])
    );
  end

  assign b_data_o = dir_dout[0];
  assign b_oe_o   = dir_drv[0];
  assign a_data_o = dir_dout[1];
  assign a_oe_o   = dir_drv[1];

  xcvr_contention_mon u_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_drv_i  (a_oe_o),
    .b_drv_i  (b_oe_o),
    .ab_oe_ni (ab_oe_ni),
    .ba_oe_ni (ba_oe_ni),
    .clash_o  (contention_o)
  );

  assert_dirs_split_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ab_en_ni && $past(ab_en_ni)) |-> $stable(b_data_o));
endmodule

// File: tb/latched_bus_xcvr_tb.sv
module latched_bus_xcvr_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_data_i = '0, b_data_i = '0;
  logic       a_drive_i = 1'b1, b_drive_i = 1'b1;
  logic       ab_en_ni = 1'b1, ab_le_ni = 1'b1, ab_oe_ni = 1'b1;
  logic       ba_en_ni = 1'b1, ba_le_ni = 1'b1, ba_oe_ni = 1'b1;
  logic [7:0] a_data_o, b_data_o;
  logic       a_oe_o, b_oe_o, contention_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  latched_bus_xcvr u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_data_i(a_data_i), .a_drive_i(a_drive_i),
    .b_data_i(b_data_i), .b_drive_i(b_drive_i),
    .ab_en_ni(ab_en_ni), .ab_le_ni(ab_le_ni), .ab_oe_ni(ab_oe_ni),
    .ba_en_ni(ba_en_ni), .ba_le_ni(ba_le_ni), .ba_oe_ni(ba_oe_ni),
    .a_data_o(a_data_o), .a_oe_o(a_oe_o),
    .b_data_o(b_data_o), .b_oe_o(b_oe_o),
    .contention_o(contention_o)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // inputs change just after a falling edge; checks 5 ns later, before the rising edge
  task automatic nxt;
    @(negedge clk_i);
  endtask

  task automatic idle;
    nxt();
    {ab_en_ni, ab_le_ni, ab_oe_ni} = 3'b111;
    {ba_en_ni, ba_le_ni, ba_oe_ni} = 3'b111;
    a_drive_i = 1'b1;
    b_drive_i = 1'b1;
  endtask

  task automatic t_reset;
    nxt();
    {ab_en_ni, ab_le_ni, ab_oe_ni} = 3'b000;
    {ba_en_ni, ba_le_ni, ba_oe_ni} = 3'b000;
    a_data_i = 8'hA5; b_data_i = 8'h3C;
    #5;
    chk("R7 b_oe in reset", b_oe_o, 0);
    chk("R7 a_oe in reset", a_oe_o, 0);
    chk("R7 b_data in reset", b_data_o, 0);
    chk("R7 a_data in reset", a_data_o, 0);
    chk("R7 contention in reset", contention_o, 0);
    {ab_en_ni, ab_le_ni, ab_oe_ni} = 3'b111;
    {ba_en_ni, ba_le_ni, ba_oe_ni} = 3'b111;
    nxt();
    rst_ni = 1'b1;
    #5;
    chk("R7 storage zero after reset", b_data_o, 0);
  endtask

  task automatic t_transparent;
    nxt();
    {ab_en_ni, ab_le_ni, ab_oe_ni} = 3'b000;
    a_data_i = 8'h5A;
    #5;
    chk("R1 A->B open", b_data_o, 8'h5A);
    chk("R5 b_oe on", b_oe_o, 1);
    a_data_i = 8'hC3;
    #1;
    chk("R1 A->B follows", b_data_o, 8'hC3);
    idle();
    {ba_en_ni, ba_le_ni, ba_oe_ni} = 3'b000;
    b_data_i = 8'h96;
    #5;
    chk("R1 B->A open", a_data_o, 8'h96);
    chk("R5 a_oe on", a_oe_o, 1);
  endtask

  task automatic t_capture_le;
    idle();
    {ab_en_ni, ab_le_ni, ab_oe_ni} = 3'b000;
    a_data_i = 8'h11;
    nxt();
    ab_le_ni = 1'b1;
    a_data_i = 8'h22;
    #5;
    chk("R2 capture on latch enable", b_data_o, 8'h11);
    chk("R5 drive stays with en/oe low", b_oe_o, 1);
    nxt();
    a_data_i = 8'h33;
    #5;
    chk("R4 closed ignores input", b_data_o, 8'h11);
  endtask

  task automatic t_capture_en;
    idle();
    {ba_en_ni, ba_le_ni, ba_oe_ni} = 3'b000;
    b_data_i = 8'h44;
    nxt();
    ba_en_ni = 1'b1;
    b_data_i = 8'h55;
    #5;
    chk("R3 capture on path enable", a_data_o, 8'h44);
    chk("R5 path enable high disables", a_oe_o, 0);
    nxt();
    b_data_i = 8'h66;
    #5;
    chk("R4 held after path enable", a_data_o, 8'h44);
  endtask

  task automatic t_disabled;
    idle();
    {ab_en_ni, ab_le_ni, ab_oe_ni} = 3'b001;
    a_data_i = 8'h6E;
    #5;
    chk("R6 pass while output off", b_data_o, 8'h6E);
    chk("R5 output enable high", b_oe_o, 0);
    nxt();
    ab_le_ni = 1'b1;
    a_data_i = 8'h77;
    #5;
    chk("R6 latched while output off", b_data_o, 8'h6E);
    nxt();
    ab_oe_ni = 1'b0;
    #5;
    chk("R6 stored value driven", b_oe_o, 1);
    chk("R6 stored data shown", b_data_o, 8'h6E);
  endtask

  task automatic t_bus_hold;
    idle();
    {ab_en_ni, ab_le_ni, ab_oe_ni} = 3'b001;
    a_data_i = 8'h9C;
    nxt();
    a_drive_i = 1'b0;
    a_data_i = 8'hFF;
    #5;
    chk("R8 keeper value", b_data_o, 8'h9C);
    nxt();
    a_data_i = 8'h01;
    #5;
    chk("R8 keeper holds", b_data_o, 8'h9C);
    a_drive_i = 1'b1;
    #1;
    chk("R8 driven again", b_data_o, 8'h01);
  endtask

  task automatic t_contention;
    idle();
    {ab_en_ni, ab_le_ni, ab_oe_ni} = 3'b000;
    {ba_en_ni, ba_le_ni, ba_oe_ni} = 3'b000;
    #5;
    chk("R9 both drive", contention_o, 1);
    nxt();
    ba_oe_ni = 1'b1;
    #5;
    chk("R9 one drives", contention_o, 0);
    nxt();
    ba_oe_ni = 1'b0;
    ab_en_ni = 1'b1;
    #5;
    chk("R9 other drives", contention_o, 0);
  endtask

  task automatic t_independent;
    idle();
    {ab_en_ni, ab_le_ni, ab_oe_ni} = 3'b000;
    a_data_i = 8'hD2;
    nxt();
    ab_le_ni = 1'b1;
    nxt();
    {ba_en_ni, ba_le_ni, ba_oe_ni} = 3'b000;
    b_data_i = 8'h2D;
    #5;
    chk("R10 B->A open", a_data_o, 8'h2D);
    chk("R10 A->B untouched", b_data_o, 8'hD2);
    nxt();
    ba_le_ni = 1'b1;
    b_data_i = 8'h7B;
    a_data_i = 8'h00;
    #5;
    chk("R10 A->B still held", b_data_o, 8'hD2);
    chk("R10 B->A held", a_data_o, 8'h2D);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_capture_le();
    t_capture_en();
    t_disabled();
    t_bus_hold();
    t_contention();
    t_independent();
    idle();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got=running exp=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule